// File: doc/BRIEF.md
# Speculative Register State with Broadside Recovery

This block holds two copies of the integer register state. The future file is the speculative copy. It takes each result as its instruction finishes execution, and those results can arrive in any order. The architectural file is the committed copy. It takes results only as they retire, in program order, and it accepts up to three retirements per cycle. Operand lookups read the future file. No structure holding in-flight results has to be searched for the current value of a register.

When a flush is signalled, every entry of the architectural file is copied into the future file at one clock edge, and the speculative state falls back to the committed state. The copy includes any retirements that happen in the same cycle, because those results are older than the instruction that caused the flush.

Each input uses a valid strobe. There is no ready signal, because every port accepts a beat on every cycle and the block never applies back-pressure.

Top module: `spec_regstate`

## Requirements
- R1: A completion write (`cmp_vld`=1, `flush`=0) stores `cmp_data` into future-file entry `cmp_idx` at the clock edge. Completions may arrive in any register order.
- R2: Retirement lanes are applied to the architectural file at the clock edge. Lane 0 is the oldest and lane RET_LANES-1 the youngest. A lane whose `ret_vld` bit is 0 has no effect. When several valid lanes name the same register, the youngest lane's data is stored.
- R3: Retirement never changes the future file, and completion never changes the architectural file. The architectural file changes only through retirement.
- R4: When `flush` is 1 at a clock edge, every future-file entry takes the architectural value that results after that same edge, including that cycle's retirements.
- R5: When `flush` and `cmp_vld` are both 1 in one cycle, the completion write is dropped and the flush copy alone sets the future file.
- R6: Each read port returns the future-file entry at `rd_idx` combinationally. If a completion write to the same register is present in that cycle and `flush` is 0, the port returns `cmp_data` instead (bypass).
- R7: Indices at or above NUM_REGS (24 to 31 at the default) are ignored by completion and retirement writes, and a read at such an index returns 0.
- R8: While `rst_n` is 0, both files clear to zero, so the two copies are identical.
- R9: The read ports are independent. Port p uses slice `rd_idx[p*IDX_W +: IDX_W]` and drives slice `rd_data[p*DATA_W +: DATA_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_vld | input | 1 | Completion write valid |
| cmp_idx | input | IDX_W (5) | Completion register index |
| cmp_data | input | DATA_W (32) | Completion result |
| ret_vld | input | RET_LANES (3) | Per-lane retirement valid, bit k for lane k |
| ret_idx | input | RET_LANES*IDX_W | Lane k index at `[k*IDX_W +: IDX_W]` |
| ret_data | input | RET_LANES*DATA_W | Lane k data at `[k*DATA_W +: DATA_W]` |
| flush | input | 1 | Restore the future file from the architectural file |
| rd_idx | input | RD_PORTS*IDX_W | Read indices, one slice per port |
| rd_data | output | RD_PORTS*DATA_W | Read results, one slice per port |

## Verification
The bench sweeps all 24 registers on both read ports. It checks writes, same-cycle bypass and out-of-range indices, and compares against a model of both files computed in the bench. Because the architectural file is visible only after a flush, each retirement pattern is followed by a flush and a full read-back:
- A design that let an older lane win over a younger one to the same register would restore the wrong value.
- A design that honoured an invalid lane would restore the wrong value.
- A design that copied the state from before the same-cycle retirement would restore the wrong value.
- A design that let a same-cycle completion survive a flush would show the completion value after recovery.
- A design that forwarded that completion during the flush would also show it.
- A design that aliased indices 24 to 31 onto real entries would corrupt registers or return nonzero reads.

// File: rtl/srs_pkg.sv
package srs_pkg;
  // Bits needed to index n entries, at least one.
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/srs_arch_file.sv
module srs_arch_file #(
  parameter int NUM_REGS  = 24,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int RET_LANES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [RET_LANES-1:0]          ret_vld,
  input  logic [RET_LANES*IDX_W-1:0]    ret_idx,
  input  logic [RET_LANES*DATA_W-1:0]   ret_data,
  output logic [NUM_REGS*DATA_W-1:0]    af_flat,
  output logic [NUM_REGS*DATA_W-1:0]    af_next_flat
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nxt;

    // Walk lanes oldest to youngest so the youngest matching lane wins.
    always_comb begin
      nxt = q;
      for (int k = 0; k < RET_LANES; k++) begin
        if (ret_vld[k] && ret_idx[k*IDX_W +: IDX_W] == IDX_W'(r))
          nxt = ret_data[k*DATA_W +: DATA_W];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end

    assign af_flat[r*DATA_W +: DATA_W]      = q;
    assign af_next_flat[r*DATA_W +: DATA_W] = nxt;
  end
endmodule

// File: rtl/srs_future_file.sv
module srs_future_file #(
  parameter int NUM_REGS = 24,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       cmp_vld,
  input  logic [IDX_W-1:0]           cmp_idx,
  input  logic [DATA_W-1:0]          cmp_data,
  input  logic [NUM_REGS*DATA_W-1:0] restore_flat,
  output logic [NUM_REGS*DATA_W-1:0] ff_flat
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [DATA_W-1:0] q;

    // Flush outranks completion: the whole file reloads in one edge.
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (flush)
        q <= restore_flat[r*DATA_W +: DATA_W];
      else if (cmp_vld && cmp_idx == IDX_W'(r))
        q <= cmp_data;
    end

    assign ff_flat[r*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/srs_read_port.sv
module srs_read_port #(
  parameter int NUM_REGS = 24,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5
) (
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [NUM_REGS*DATA_W-1:0] ff_flat,
  input  logic                       byp_vld,
  input  logic [IDX_W-1:0]           byp_idx,
  input  logic [DATA_W-1:0]          byp_data,
  output logic [DATA_W-1:0]          rd_data
);
  logic              found;
  logic [DATA_W-1:0] stored;

  always_comb begin
    found  = 1'b0;
    stored = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rd_idx == IDX_W'(r)) begin
        found  = 1'b1;
        stored = ff_flat[r*DATA_W +: DATA_W];
      end
    end
  end

  // Forward a same-cycle completion only for an index that names a real entry.
  assign rd_data = (found && byp_vld && byp_idx == rd_idx) ? byp_data : stored;
endmodule

// File: rtl/spec_regstate.sv
module spec_regstate
  import srs_pkg::*;
#(
  parameter int NUM_REGS  = 24,
  parameter int DATA_W    = 32,
  parameter int RET_LANES = 3,
  parameter int RD_PORTS  = 2,
  localparam int IDX_W    = idx_bits(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmp_vld,
  input  logic [IDX_W-1:0]            cmp_idx,
  input  logic [DATA_W-1:0]           cmp_data,
  input  logic [RET_LANES-1:0]        ret_vld,
  input  logic [RET_LANES*IDX_W-1:0]  ret_idx,
  input  logic [RET_LANES*DATA_W-1:0] ret_data,
  input  logic                        flush,
  input  logic [RD_PORTS*IDX_W-1:0]   rd_idx,
  output logic [RD_PORTS*DATA_W-1:0]  rd_data
);
  logic [NUM_REGS*DATA_W-1:0] af_flat;
  logic [NUM_REGS*DATA_W-1:0] af_next_flat;
  logic [NUM_REGS*DATA_W-1:0] ff_flat;
  logic                       byp_vld;

  assign byp_vld = cmp_vld & ~flush;

  srs_arch_file #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .RET_LANES(RET_LANES)
  ) u_arch (
    .clk(clk), .rst_n(rst_n),
    .ret_vld(ret_vld), .ret_idx(ret_idx), .ret_data(ret_data),
    .af_flat(af_flat), .af_next_flat(af_next_flat)
  );

  srs_future_file #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_fut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cmp_vld(cmp_vld), .cmp_idx(cmp_idx), .cmp_data(cmp_data),
    .restore_flat(af_next_flat), .ff_flat(ff_flat)
  );

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    srs_read_port #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_rd (
      .rd_idx(rd_idx[p*IDX_W +: IDX_W]),
      .ff_flat(ff_flat),
      .byp_vld(byp_vld), .byp_idx(cmp_idx), .byp_data(cmp_data),
      .rd_data(rd_data[p*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int NUM_REGS = 24,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5,
  parameter int RET_LANES = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flush,
  input logic                       cmp_vld,
  input logic [IDX_W-1:0]           cmp_idx,
  input logic [DATA_W-1:0]          cmp_data,
  input logic [RET_LANES-1:0]       ret_vld,
  input logic [IDX_W-1:0]           rd_idx0,
  input logic [DATA_W-1:0]          rd_data0,
  input logic [NUM_REGS*DATA_W-1:0] ff_flat,
  input logic [NUM_REGS*DATA_W-1:0] af_flat
);
  localparam logic [IDX_W:0] NREG = (IDX_W+1)'(NUM_REGS);

  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (ff_flat == '0 && af_flat == '0));

  a_r4_flush_restore: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ff_flat == af_flat));

  a_r3_arch_only_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld == '0) |=> $stable(af_flat));

  a_r1_future_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !cmp_vld) |=> $stable(ff_flat));

  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld && !flush && cmp_idx == rd_idx0 && {1'b0, cmp_idx} < NREG)
      |-> (rd_data0 == cmp_data));

  a_r7_range_read: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rd_idx0} >= NREG) |-> (rd_data0 == '0));
endmodule

bind spec_regstate srs_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .RET_LANES(RET_LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .cmp_vld(cmp_vld), .cmp_idx(cmp_idx), .cmp_data(cmp_data),
  .ret_vld(ret_vld),
  .rd_idx0(rd_idx[IDX_W-1:0]), .rd_data0(rd_data[DATA_W-1:0]),
  .ff_flat(ff_flat), .af_flat(af_flat)
);

// File: tb/spec_regstate_tb.sv
module spec_regstate_tb;
  localparam int NR = 24;
  localparam int DW = 32;
  localparam int RL = 3;
  localparam int RP = 2;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmp_vld;
  logic [IW-1:0] cmp_idx;
  logic [DW-1:0] cmp_data;
  logic [RL-1:0] ret_vld;
  logic [RL*IW-1:0] ret_idx;
  logic [RL*DW-1:0] ret_data;
  logic          flush;
  logic [RP*IW-1:0] rd_idx;
  logic [RP*DW-1:0] rd_data;

  logic [DW-1:0] ff_m [NR];
  logic [DW-1:0] af_m [NR];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  spec_regstate u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmp_vld(cmp_vld), .cmp_idx(cmp_idx), .cmp_data(cmp_data),
    .ret_vld(ret_vld), .ret_idx(ret_idx), .ret_data(ret_data),
    .flush(flush), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(input int i, input logic [DW-1:0] s);
    return 32'hC0DE0000 ^ (DW'(i) * 32'h01030507) ^ s;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    cmp_vld = 0; cmp_idx = '0; cmp_data = '0;
    ret_vld = '0; ret_idx = '0; ret_data = '0; flush = 0;
  endtask

  task automatic set_lane(input int k, input logic v, input int idx, input logic [DW-1:0] d);
    ret_vld[k] = v;
    ret_idx[k*IW +: IW] = IW'(idx);
    ret_data[k*DW +: DW] = d;
  endtask

  // Model update from the requirements, using inputs held for the coming edge.
  task automatic tick();
    logic [DW-1:0] an [NR];
    int ix;
    for (int r = 0; r < NR; r++) an[r] = af_m[r];
    for (int k = 0; k < RL; k++) begin
      ix = int'(ret_idx[k*IW +: IW]);
      if (ret_vld[k] && ix < NR) an[ix] = ret_data[k*DW +: DW];
    end
    if (flush) begin
      for (int r = 0; r < NR; r++) ff_m[r] = an[r];
    end else if (cmp_vld && int'(cmp_idx) < NR) begin
      ff_m[int'(cmp_idx)] = cmp_data;
    end
    for (int r = 0; r < NR; r++) af_m[r] = an[r];
    @(posedge clk); #1;
    idle();
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_idx[IW-1:0]  = IW'(i);
      rd_idx[IW +: IW] = IW'(31 - i);
      #1;
      chk(req, rd_data[DW-1:0], (i < NR) ? ff_m[i] : '0);
      chk({req, " R9"}, rd_data[DW +: DW], ((31 - i) < NR) ? ff_m[31 - i] : '0);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired got=%h exp=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(); rd_idx = '0; rst_n = 0;
    for (int r = 0; r < NR; r++) begin ff_m[r] = '0; af_m[r] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sweep("R8 reset");

    // R1: completions in descending order.
    for (int i = NR - 1; i >= 0; i--) begin
      cmp_vld = 1; cmp_idx = IW'(i); cmp_data = pat(i, 32'h11);
      tick();
    end
    sweep("R1 completion");

    // R6: same-cycle bypass on port 0, port 1 sees stored neighbour.
    for (int i = 0; i < NR; i++) begin
      cmp_vld = 1; cmp_idx = IW'(i); cmp_data = pat(i, 32'h22);
      rd_idx[IW-1:0] = IW'(i);
      rd_idx[IW +: IW] = IW'((i + 1) % NR);
      #1;
      chk("R6 bypass", rd_data[DW-1:0], pat(i, 32'h22));
      chk("R6 R9 other port", rd_data[DW +: DW], ff_m[(i + 1) % NR]);
      tick();
    end

    // R7: out-of-range writes ignored.
    for (int i = NR; i < 32; i++) begin
      cmp_vld = 1; cmp_idx = IW'(i); cmp_data = 32'hDEADBEEF;
      rd_idx[IW-1:0] = IW'(i);
      #1;
      chk("R7 range read no bypass", rd_data[DW-1:0], '0);
      tick();
    end
    sweep("R7 range write");

    // R2/R3: retire every register across lanes, future file untouched.
    for (int i = 0; i < NR; i += RL) begin
      for (int k = 0; k < RL; k++) set_lane(k, 1'b1, i + k, pat(i + k, 32'h33));
      tick();
    end
    sweep("R3 retire leaves future");
    flush = 1; tick();
    sweep("R4 flush restore");

    // R3: completion does not reach the architectural file.
    cmp_vld = 1; cmp_idx = 5'd7; cmp_data = 32'h77777777; tick();
    flush = 1; tick();
    rd_idx[IW-1:0] = 5'd7; #1;
    chk("R3 completion not committed", rd_data[DW-1:0], pat(7, 32'h33));

    // R2: same register in all lanes, youngest wins; invalid lane ignored.
    set_lane(0, 1'b1, 3, 32'hAAAA0000);
    set_lane(1, 1'b1, 3, 32'hBBBB0000);
    set_lane(2, 1'b0, 3, 32'hCCCC0000);
    set_lane(2, 1'b0, 9, 32'hCCCC0000);
    tick();
    set_lane(0, 1'b1, 4, 32'h40000001);
    set_lane(2, 1'b1, 4, 32'h40000003);
    set_lane(1, 1'b1, 30, 32'h5A5A5A5A);
    tick();
    flush = 1; tick();
    rd_idx[IW-1:0] = 5'd3; rd_idx[IW +: IW] = 5'd4; #1;
    chk("R2 younger lane wins", rd_data[DW-1:0], 32'hBBBB0000);
    chk("R2 lane2 over lane0", rd_data[DW +: DW], 32'h40000003);
    rd_idx[IW-1:0] = 5'd9; #1;
    chk("R2 invalid lane ignored", rd_data[DW-1:0], pat(9, 32'h33));
    sweep("R2 R7 after retire mix");

    // R5: flush beats completion; no forwarding during flush.
    cmp_vld = 1; cmp_idx = 5'd12; cmp_data = 32'h12121212; flush = 1;
    rd_idx[IW-1:0] = 5'd12; #1;
    chk("R5 no bypass during flush", rd_data[DW-1:0], ff_m[12]);
    tick();
    #1 chk("R5 completion dropped", rd_data[DW-1:0], pat(12, 32'h33));

    // R4: flush with same-cycle retirement includes it.
    for (int i = 0; i < NR; i++) begin
      cmp_vld = 1; cmp_idx = IW'(i); cmp_data = pat(i, 32'h44); tick();
    end
    set_lane(0, 1'b1, 20, 32'h20202020);
    set_lane(2, 1'b1, 0, 32'h00000F0F);
    flush = 1; tick();
    sweep("R4 flush with retire");
    rd_idx[IW-1:0] = 5'd20; #1;
    chk("R4 same-cycle retire copied", rd_data[DW-1:0], 32'h20202020);

    // R8: reset mid-run clears both copies.
    rst_n = 0; tick(); tick();
    for (int r = 0; r < NR; r++) begin ff_m[r] = '0; af_m[r] = '0; end
    rst_n = 1;
    sweep("R8 reset again");
    flush = 1; tick();
    sweep("R8 arch cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule